// File: doc/BRIEF.md
# Dual-Bank Non-Volatile Image Validator

This block inspects two equally sized images of non-volatile settings that sit one after the other in a byte-wide memory, and decides which of the two is current. Each image carries a short header. The header holds a marker byte, an 8-bit header sum, a 32-bit running checksum over the bulk of the image, and a 32-bit generation counter. The block streams every byte of both images through its synchronous read port, one byte per clock. It then reports for each image whether all checks passed, together with its generation.

Software or a boot sequencer pulses `start`. The block stays `busy` while it scans, then pulses `done` and presents the index of the image to load. An image that fails any check is reported with generation zero, so the newest image that passed its checks wins. On a tie, image 0 wins.

Top module: `nvbank_select`

## Requirements
- R1: After `start` is accepted, `rd_en` is high for exactly 2*BANK_BYTES consecutive cycles. `rd_addr` runs from 0 to 2*BANK_BYTES-1 in steps of one. Bit OFF_W of the address selects the image and the lower OFF_W bits are the byte offset. `rd_data` carries the addressed byte in the cycle after the request.
- R2: An image passes only if its byte at offset 0 equals 0x5A.
- R3: The header sum is the byte at offset 0 plus the bytes at offsets 2 to 15, formed as a 16-bit total. The total is folded by adding its upper byte into its lower byte until it fits in 8 bits. The image passes only if the result equals the byte at offset 1.
- R4: The running checksum starts with low = 1 and high = 0. For each byte at offsets 0x14 to BANK_BYTES-1, in order, low becomes (low + byte) mod 65521 and then high becomes (high + low) mod 65521. The image passes only if {high, low} equals the big-endian 32-bit word at offsets 0x10 to 0x13.
- R5: The generation is the big-endian 32-bit word at offsets 0x14 to 0x17. Each image has an ok flag (`bank0_ok`, `bank1_ok`) that is 1 when all of R2 to R4 pass. Its reported generation is this word when ok is 1 and zero otherwise.
- R6: `active_bank` is 1 only when the reported generation of image 0 is strictly less than that of image 1. Otherwise it is 0, so a tie selects image 0.
- R7: `start` is accepted when `busy` is low. `busy` rises at the accepting edge. `done` is high for exactly one cycle, 2*BANK_BYTES+3 clock edges after the accepting edge, and `busy` is low from that same edge. `active_bank` holds its value while the block is idle.
- R8: A `start` pulse while `busy` is high has no effect: the scan in progress keeps its address sequence and its completion time.
- R9: After reset, `busy`, `done`, `rd_en`, both ok flags, both generations and `active_bank` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan of both images |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W (14) | Memory byte address {image, offset} |
| rd_data | input | 8 | Memory read data, one cycle after request |
| bank0_ok | output | 1 | Image 0 passed all checks |
| bank1_ok | output | 1 | Image 1 passed all checks |
| bank0_gen | output | 32 | Reported generation of image 0 |
| bank1_gen | output | 32 | Reported generation of image 1 |
| active_bank | output | 1 | Selected image index |

## Verification
Both images are built with valid headers and distinct body contents, with the newer one first in image 0 and then in image 1. A generation pair that only orders correctly when read big-endian tells a byte-order mistake apart from a good read. A tie is tried with a header whose sum needs two folds, which exposes a single-fold reduction. Single faults are then placed in only one image at a time: a wrong marker byte with a header sum made consistent with it, a wrong header sum, and one flipped body byte. Each fault is put in the image that would otherwise win, so each check is seen to veto the selection on its own. A final run breaks both images, and one run pulses `start` in the middle of a scan.

// File: rtl/nvbs_pkg.sv
package nvbs_pkg;

  localparam int GEN_W = 32;

  typedef struct packed {
    logic             ok;
    logic [GEN_W-1:0] gen;
  } bank_res_t;

  // end-around-carry reduction of a 16-bit total down to 8 bits
  function automatic logic [7:0] fold8(input logic [15:0] total);
    logic [15:0] t;
    t = total;
    for (int i = 0; i < 3; i++) begin
      if (t[15:8] != 8'h00) t = {8'h00, t[7:0]} + {8'h00, t[15:8]};
    end
    return t[7:0];
  endfunction

  // (a + b) mod m for a, b already below m
  function automatic logic [15:0] mod_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic [16:0] m);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= m) s = s - m;
    return s[15:0];
  endfunction

endpackage

// File: rtl/nvbs_seq.sv
module nvbs_seq #(
  parameter int BANK_BYTES = 8192,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fin,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              byte_vld,
  output logic [OFF_W-1:0]  byte_off,
  output logic              eval,
  output logic              eval_bank
);

  localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_W'(BANK_BYTES - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(2 * BANK_BYTES - 1);

  logic              busy_q, rd_en_q, vld_q, eval_q, ebank_q;
  logic [ADDR_W-1:0] addr_q, baddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      rd_en_q <= 1'b0;
      addr_q  <= '0;
      vld_q   <= 1'b0;
      baddr_q <= '0;
      eval_q  <= 1'b0;
      ebank_q <= 1'b0;
    end else begin
      // request pipeline mirrors the one-cycle memory latency
      vld_q   <= rd_en_q;
      baddr_q <= addr_q;
      eval_q  <= vld_q && (baddr_q[OFF_W-1:0] == OFF_LAST);
      ebank_q <= baddr_q[OFF_W];
      if (!busy_q && start) begin
        busy_q  <= 1'b1;
        rd_en_q <= 1'b1;
        addr_q  <= '0;
      end else begin
        if (rd_en_q) begin
          if (addr_q == ADDR_LAST) rd_en_q <= 1'b0;
          else                     addr_q  <= addr_q + 1'b1;
        end
        if (fin) busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign rd_en     = rd_en_q;
  assign rd_addr   = addr_q;
  assign byte_vld  = vld_q;
  assign byte_off  = baddr_q[OFF_W-1:0];
  assign eval      = eval_q;
  assign eval_bank = ebank_q;

endmodule

// File: rtl/nvbs_hdr_chk.sv
module nvbs_hdr_chk
  import nvbs_pkg::*;
#(
  parameter int          OFF_W    = 13,
  parameter logic [7:0]  SIG_BYTE = 8'h5A,
  parameter int          CK_POS   = 1,
  parameter int          HDR_END  = 16,
  parameter int          SUM_POS  = 16,
  parameter int          GEN_POS  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [OFF_W-1:0] byte_off,
  input  logic [7:0]       byte_dat,
  output logic             hdr_ok,
  output logic [31:0]      stored_sum,
  output logic [GEN_W-1:0] gen
);

  localparam logic [OFF_W-1:0] CK_OFF   = OFF_W'(CK_POS);
  localparam logic [OFF_W-1:0] HDR_LO   = OFF_W'(CK_POS + 1);
  localparam logic [OFF_W-1:0] HDR_HI   = OFF_W'(HDR_END);
  localparam logic [OFF_W-1:0] SUM_LO   = OFF_W'(SUM_POS);
  localparam logic [OFF_W-1:0] SUM_HI   = OFF_W'(SUM_POS + 4);
  localparam logic [OFF_W-1:0] GEN_LO   = OFF_W'(GEN_POS);
  localparam logic [OFF_W-1:0] GEN_HI   = OFF_W'(GEN_POS + GEN_W / 8);

  logic [7:0]       sig_q, ck_q;
  logic [15:0]      hsum_q;
  logic [31:0]      stored_q;
  logic [GEN_W-1:0] gen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q    <= '0;
      ck_q     <= '0;
      hsum_q   <= '0;
      stored_q <= '0;
      gen_q    <= '0;
    end else if (byte_vld) begin
      if (byte_off == '0) begin
        sig_q  <= byte_dat;
        hsum_q <= {8'h00, byte_dat};
      end
      if (byte_off == CK_OFF) ck_q <= byte_dat;
      if (byte_off >= HDR_LO && byte_off < HDR_HI) hsum_q <= hsum_q + {8'h00, byte_dat};
      // multi-byte fields arrive most significant byte first
      if (byte_off >= SUM_LO && byte_off < SUM_HI) stored_q <= {stored_q[23:0], byte_dat};
      if (byte_off >= GEN_LO && byte_off < GEN_HI) gen_q <= {gen_q[GEN_W-9:0], byte_dat};
    end
  end

  assign hdr_ok     = (sig_q == SIG_BYTE) && (fold8(hsum_q) == ck_q);
  assign stored_sum = stored_q;
  assign gen        = gen_q;

endmodule

// File: rtl/nvbs_long_sum.sv
module nvbs_long_sum
  import nvbs_pkg::*;
#(
  parameter int OFF_W      = 13,
  parameter int LONG_START = 20,
  parameter int MODULUS    = 65521
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [OFF_W-1:0] byte_off,
  input  logic [7:0]       byte_dat,
  output logic [31:0]      sum_out
);

  localparam logic [OFF_W-1:0] START_OFF = OFF_W'(LONG_START);
  localparam logic [16:0]      MOD_V     = 17'(MODULUS);

  logic [15:0] lo_q, hi_q;
  logic [15:0] lo_n, hi_n;

  always_comb begin
    lo_n = mod_add(lo_q, {8'h00, byte_dat}, MOD_V);
    hi_n = mod_add(hi_q, lo_n, MOD_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 16'd1;
      hi_q <= 16'd0;
    end else if (byte_vld) begin
      if (byte_off == '0) begin
        // every image restarts the accumulators
        lo_q <= 16'd1;
        hi_q <= 16'd0;
      end else if (byte_off >= START_OFF) begin
        lo_q <= lo_n;
        hi_q <= hi_n;
      end
    end
  end

  assign sum_out = {hi_q, lo_q};

endmodule

// File: rtl/nvbs_pick.sv
module nvbs_pick
  import nvbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             eval,
  input  logic             eval_bank,
  input  logic             hdr_ok,
  input  logic [31:0]      stored_sum,
  input  logic [31:0]      long_sum,
  input  logic [GEN_W-1:0] gen,
  output logic             fin,
  output logic             done,
  output logic             active_bank,
  output bank_res_t        res0,
  output bank_res_t        res1
);

  localparam int NUM_BANKS = 2;

  bank_res_t res_q [NUM_BANKS];
  bank_res_t res_n;
  logic      fin_q, done_q, act_q;

  always_comb begin
    res_n.ok  = hdr_ok && (stored_sum == long_sum);
    res_n.gen = res_n.ok ? gen : '0;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                res_q[b] <= '0;
      else if (eval && (eval_bank == b[0]))   res_q[b] <= res_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      fin_q  <= eval && eval_bank;
      done_q <= fin_q;
      if (fin_q) act_q <= (res_q[0].gen < res_q[1].gen);
    end
  end

  assign fin         = fin_q;
  assign done        = done_q;
  assign active_bank = act_q;
  assign res0        = res_q[0];
  assign res1        = res_q[1];

endmodule

// File: rtl/nvbank_select.sv
module nvbank_select
  import nvbs_pkg::*;
#(
  parameter int         BANK_BYTES = 8192,
  parameter logic [7:0] SIG_BYTE   = 8'h5A,
  parameter int         MODULUS    = 65521,
  localparam int        OFF_W      = $clog2(BANK_BYTES),
  localparam int        ADDR_W     = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              bank0_ok,
  output logic              bank1_ok,
  output logic [31:0]       bank0_gen,
  output logic [31:0]       bank1_gen,
  output logic              active_bank
);

  localparam int CK_POS   = 1;
  localparam int HDR_END  = 16;
  localparam int SUM_POS  = HDR_END;
  localparam int GEN_POS  = SUM_POS + 4;

  logic             fin, byte_vld, eval, eval_bank, hdr_ok;
  logic [OFF_W-1:0] byte_off;
  logic [31:0]      stored_sum, long_sum;
  logic [GEN_W-1:0] gen;
  bank_res_t        res0, res1;

  nvbs_seq #(.BANK_BYTES(BANK_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .fin(fin), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .byte_vld(byte_vld), .byte_off(byte_off),
    .eval(eval), .eval_bank(eval_bank)
  );

  nvbs_hdr_chk #(
    .OFF_W(OFF_W), .SIG_BYTE(SIG_BYTE), .CK_POS(CK_POS),
    .HDR_END(HDR_END), .SUM_POS(SUM_POS), .GEN_POS(GEN_POS)
  ) u_hdr (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_off(byte_off), .byte_dat(rd_data),
    .hdr_ok(hdr_ok), .stored_sum(stored_sum), .gen(gen)
  );

  // the running checksum begins where the generation field begins
  nvbs_long_sum #(.OFF_W(OFF_W), .LONG_START(GEN_POS), .MODULUS(MODULUS)) u_long (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_off(byte_off), .byte_dat(rd_data),
    .sum_out(long_sum)
  );

  nvbs_pick u_pick (
    .clk(clk), .rst(rst), .eval(eval), .eval_bank(eval_bank), .hdr_ok(hdr_ok),
    .stored_sum(stored_sum), .long_sum(long_sum), .gen(gen), .fin(fin), .done(done),
    .active_bank(active_bank), .res0(res0), .res1(res1)
  );

  assign bank0_ok  = res0.ok;
  assign bank1_ok  = res1.ok;
  assign bank0_gen = res0.gen;
  assign bank1_gen = res1.gen;

endmodule

// File: rtl/nvbank_select_chk.sv
module nvbank_select_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              bank0_ok,
  input logic              bank1_ok,
  input logic [31:0]       bank0_gen,
  input logic [31:0]       bank1_gen,
  input logic              active_bank
);

  AST_RD_IN_SCAN:   assert property (@(posedge clk) disable iff (rst) rd_en |-> busy); // R1
  AST_ADDR_STEP:    assert property (@(posedge clk) disable iff (rst)
                      rd_en && $past(rd_en) |-> rd_addr == ($past(rd_addr) + 1'b1)); // R1
  AST_BAD0_ZERO:    assert property (@(posedge clk) disable iff (rst) !bank0_ok |-> bank0_gen == '0); // R5
  AST_BAD1_ZERO:    assert property (@(posedge clk) disable iff (rst) !bank1_ok |-> bank1_gen == '0); // R5
  AST_PICK_NEWER:   assert property (@(posedge clk) disable iff (rst)
                      done && (bank0_gen < bank1_gen) |-> active_bank); // R6
  AST_PICK_DEFAULT: assert property (@(posedge clk) disable iff (rst)
                      done && !(bank0_gen < bank1_gen) |-> !active_bank); // R6
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R7
  AST_START_TAKEN:  assert property (@(posedge clk) disable iff (rst) !busy && start |=> busy); // R7
  AST_HOLD_IDLE:    assert property (@(posedge clk) disable iff (rst)
                      !busy && !done |-> $stable(active_bank)); // R7
  AST_START_BUSY:   assert property (@(posedge clk) disable iff (rst)
                      busy && start |=> busy || done); // R8

endmodule

bind nvbank_select nvbank_select_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .rd_en(rd_en),
  .rd_addr(rd_addr), .bank0_ok(bank0_ok), .bank1_ok(bank1_ok), .bank0_gen(bank0_gen),
  .bank1_gen(bank1_gen), .active_bank(active_bank)
);

// File: tb/nvbank_select_bench.sv
`timescale 1ns/1ps
module nvbank_select_bench;

  localparam int BANK   = 8192;
  localparam int ADDR_W = 14;
  localparam int EXP_N  = 1 + 2 * BANK + 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy, done, rd_en, bank0_ok, bank1_ok, active_bank;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic [31:0]       bank0_gen, bank1_gen;

  int checks = 0;
  int fails  = 0;
  logic finished = 1'b0;

  logic [7:0] hdr_img [0:1][0:23];
  logic       corrupt [0:1];
  logic [7:0] run_seed;

  always #2 clk = ~clk;

  nvbank_select u_nvbank_select (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .bank0_ok(bank0_ok), .bank1_ok(bank1_ok),
    .bank0_gen(bank0_gen), .bank1_gen(bank1_gen), .active_bank(active_bank)
  );

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    logic [12:0] off;
    logic        bk;
    logic [7:0]  v;
    off = a[12:0];
    bk  = a[13];
    if (off < 13'd24) return hdr_img[bk][off[4:0]];
    v = 8'(int'(off) * 37) ^ 8'(off >> 6) ^ (bk ? 8'h5c : 8'h00) ^ run_seed;
    if (corrupt[bk] && off == 13'h1234) v = v ^ 8'h10;
    return v;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_byte(rd_addr);

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // mode: 0 good, 1 wrong marker, 2 wrong header sum, 3 flipped body byte
  task automatic build(input int b, input logic [31:0] g, input int mode, input bit dbl);
    int sum, lo, hi;
    for (int i = 0; i < 24; i++) hdr_img[b][i] = 8'h00;
    corrupt[b] = 1'b0;
    hdr_img[b][0] = (mode == 1) ? 8'hA5 : 8'h5A;
    for (int i = 2; i < 16; i++)
      hdr_img[b][i] = dbl ? ((i == 2) ? 8'hB2 : 8'hFF) : 8'(8'h30 + i + b * 3);
    sum = hdr_img[b][0];
    for (int i = 2; i < 16; i++) sum += hdr_img[b][i];
    while (sum > 255) sum = (sum & 255) + (sum >> 8);
    hdr_img[b][1] = (mode == 2) ? (8'(sum) ^ 8'h01) : 8'(sum);
    hdr_img[b][20] = g[31:24]; hdr_img[b][21] = g[23:16];
    hdr_img[b][22] = g[15:8];  hdr_img[b][23] = g[7:0];
    lo = 1; hi = 0;
    for (int off = 20; off < BANK; off++) begin
      lo = (lo + int'(mem_byte(ADDR_W'(b * BANK + off)))) % 65521;
      hi = (hi + lo) % 65521;
    end
    hdr_img[b][16] = 8'(hi >> 8); hdr_img[b][17] = 8'(hi);
    hdr_img[b][18] = 8'(lo >> 8); hdr_img[b][19] = 8'(lo);
    if (mode == 3) corrupt[b] = 1'b1;
  endtask

  function automatic string tag_of(input int mode);
    case (mode)
      1:       return "R2";
      2:       return "R3";
      3:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_case(input string label, input logic [31:0] g0, input int m0,
                          input logic [31:0] g1, input int m1, input bit dbl,
                          input bit poke, input logic [7:0] seed);
    int n, rd_seen, rd_bad;
    logic [31:0] eg0, eg1;
    run_seed = seed;
    build(0, g0, m0, dbl);
    build(1, g1, m1, 1'b0);
    eg0 = (m0 == 0) ? g0 : 32'd0;
    eg1 = (m1 == 0) ? g1 : 32'd0;
    rd_seen = 0; rd_bad = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk); n = 1;
    @(negedge clk) start = 1'b0;
    while (!done && n < 20000) begin
      if (rd_en) begin
        if (rd_addr !== ADDR_W'(rd_seen)) rd_bad++;
        rd_seen++;
      end
      start = (poke && n == 100);
      @(posedge clk); n++;
      @(negedge clk);
    end
    start = 1'b0;
    $display("case %s: done after %0d edges", label, n);
    check("R1", {label, " read count"}, rd_seen, 2 * BANK);
    check("R1", {label, " address order errors"}, rd_bad, 0);
    check(poke ? "R8" : "R7", {label, " done latency"}, n, EXP_N);
    check("R7", {label, " busy at done"}, busy, 0);
    check(dbl ? "R3" : tag_of(m0), {label, " bank0_ok"}, bank0_ok, (m0 == 0));
    check(tag_of(m1), {label, " bank1_ok"}, bank1_ok, (m1 == 0));
    check("R5", {label, " bank0_gen"}, bank0_gen, eg0);
    check("R5", {label, " bank1_gen"}, bank1_gen, eg1);
    check("R6", {label, " active_bank"}, active_bank, (eg0 < eg1));
    @(posedge clk); @(negedge clk);
    check("R7", {label, " done one cycle"}, done, 0);
    check("R7", {label, " active held"}, active_bank, (eg0 < eg1));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    run_seed = 8'h00;
    corrupt[0] = 1'b0; corrupt[1] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9 reset state
    check("R9", "busy after reset", busy, 0);
    check("R9", "done after reset", done, 0);
    check("R9", "rd_en after reset", rd_en, 0);
    check("R9", "ok flags after reset", {bank0_ok, bank1_ok}, 0);
    check("R9", "gens after reset", bank0_gen | bank1_gen, 0);
    check("R9", "active after reset", active_bank, 0);

    run_case("newer_in_0",  32'd5,        0, 32'd3,        0, 1'b0, 1'b0, 8'h11);
    run_case("big_endian",  32'h000000FF, 0, 32'h01000000, 0, 1'b0, 1'b0, 8'h22);
    run_case("tie_2fold",   32'd9,        0, 32'd9,        0, 1'b1, 1'b0, 8'h33);
    run_case("bad_marker1", 32'd2,        0, 32'd50,       1, 1'b0, 1'b0, 8'h44);
    run_case("bad_hsum0",   32'd80,       2, 32'd4,        0, 1'b0, 1'b0, 8'h55);
    run_case("bad_body0",   32'h7000,     3, 32'h10,       0, 1'b0, 1'b1, 8'h66);
    run_case("both_bad",    32'd6,        1, 32'd7,        3, 1'b0, 1'b0, 8'h77);

    finished = 1'b1;
    finish_run();
  end

endmodule